// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter File

This block holds a bank of counters that many agents update in place, each update performed atomically in a single clock cycle. The counters sit in a byte-addressed store, and an access can treat any naturally aligned 1, 2, 4 or 8 byte slice of that store as one counter. Every request carries a request word. The low bits of the word give the byte address. Bits 12:11 give the operand size. The upper bits either carry the operation for a store-type request or carry a signed increment for a load-type request.

A load-type request adds the increment packed into its request word and returns the value the counter held before that add. A store-type request takes its operand from the write bus. One mode bit decides whether the block adds that operand to the counter or overwrites the counter with it. Storage is big-endian inside each 8-byte word. A request the next cycle at the same address sees the result at once, with no stall. A misaligned request changes nothing and is answered with an error flag.

Top module: `atomic_counter_file`

## Requirements
- R1: After synchronous reset every counter byte reads as zero, and `rsp_valid` and `rsp_err` are low.
- R2: Each request with `req_valid` high produces `rsp_valid` high on the next cycle. For an aligned load-type request, `rsp_data` holds the counter's previous value sign-extended to 64 bits. For a store-type request, `rsp_data` is zero.
- R3: A load-type request takes a 22-bit two's-complement increment from request bits 35:14. The increment is sign-extended to the operand width, and the counter becomes the old value plus the increment, wrapping modulo the operand width.
- R4: A store-type request with request bit 13 equal to 0 adds the low operand-width bits of `req_wdata` to the counter, wrapping modulo the operand width.
- R5: A store-type request with request bit 13 equal to 1 overwrites the counter with the low operand-width bits of `req_wdata`.
- R6: Request bits 12:11 select the operand size: 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. An update never alters bytes outside its operand.
- R7: Byte order is big-endian. The byte at an address whose low three bits are 0 is the most significant byte of the 64-bit word at that 8-byte boundary.
- R8: A request whose byte address (bits 10:0) is not a multiple of the operand size gets `rsp_err` high and `rsp_data` zero on the next cycle, and leaves all counters unchanged. Byte-size requests are never misaligned.
- R9: Requests on consecutive cycles to the same counter each see the result of the one before, without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_load | input | 1 | 1 = load-type fetch-and-add, 0 = store-type |
| req_addr | input | 36 | Request word: increment [35:14], store mode [13], size [12:11], byte address [10:0] |
| req_wdata | input | 64 | Store operand, right-justified |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was misaligned and rejected |
| rsp_data | output | 64 | Sign-extended previous counter value for loads, zero otherwise |

## Verification
The bench builds the block with its default 2048-byte store, which puts the full 11-bit byte address range within reach. That range includes the top word at byte 2040. Random traffic is confined to the lowest 64 bytes, so that narrow and wide operands overlap the same words often. This exercises cross-size byte preservation, big-endian lane placement and back-to-back read-after-write on a shared counter.

// File: rtl/acf_pkg.sv
package acf_pkg;

    localparam int DATA_W   = 64;
    localparam int LANE_W   = 3;
    localparam int INC_LO   = 14;
    localparam int INC_HI   = 35;
    localparam int INC_W    = INC_HI - INC_LO + 1;
    localparam int MODE_BIT = 13;
    localparam int SIZE_LO  = 11;
    localparam int REQ_W    = INC_HI + 1;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } opsize_e;

    typedef struct packed {
        logic              misaligned;
        logic              overwrite;
        opsize_e           size;
        logic [LANE_W-1:0] lane;
        logic [DATA_W-1:0] operand;
    } req_dec_t;

    function automatic logic [DATA_W-1:0] size_mask(opsize_e s);
        case (s)
            SZ_8:    return 64'h0000_0000_0000_00FF;
            SZ_16:   return 64'h0000_0000_0000_FFFF;
            SZ_32:   return 64'h0000_0000_FFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] sext_sz(logic [DATA_W-1:0] v, opsize_e s);
        case (s)
            SZ_8:    return {{56{v[7]}},  v[7:0]};
            SZ_16:   return {{48{v[15]}}, v[15:0]};
            SZ_32:   return {{32{v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [LANE_W-1:0] align_bits(opsize_e s);
        case (s)
            SZ_8:    return 3'b000;
            SZ_16:   return 3'b001;
            SZ_32:   return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [3:0] nbytes(opsize_e s);
        return 4'd1 << s;
    endfunction

endpackage

// File: rtl/acf_decode.sv
module acf_decode
    import acf_pkg::*;
#(
    parameter int ADDR_W = 11,
    localparam int IDX_W = ADDR_W - LANE_W
) (
    input  logic                is_load,
    input  logic [REQ_W-1:0]    addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [IDX_W-1:0]    word_idx,
    output req_dec_t            dec
);
    logic [INC_W-1:0] inc;
    opsize_e          sz;

    assign inc      = addr[INC_HI:INC_LO];
    assign sz       = opsize_e'(addr[SIZE_LO+1:SIZE_LO]);
    assign word_idx = addr[ADDR_W-1:LANE_W];

    always_comb begin
        dec.size       = sz;
        dec.lane       = addr[LANE_W-1:0];
        dec.misaligned = |(addr[LANE_W-1:0] & align_bits(sz));
        dec.overwrite  = !is_load && addr[MODE_BIT];
        dec.operand    = is_load ? {{(DATA_W-INC_W){inc[INC_W-1]}}, inc} : wdata;
    end
endmodule

// File: rtl/acf_lane_alu.sv
module acf_lane_alu
    import acf_pkg::*;
(
    input  logic [DATA_W-1:0] word_in,
    input  req_dec_t          dec,
    output logic [DATA_W-1:0] old_val,
    output logic [DATA_W-1:0] word_out
);
    logic [3:0]        rem;
    logic [6:0]        shamt;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] field_new;

    always_comb begin
        mask      = size_mask(dec.size);
        // Big-endian: lane 0 holds the most significant byte.
        rem       = 4'd8 - {1'b0, dec.lane} - nbytes(dec.size);
        shamt     = {rem, 3'b000};
        old_val   = (word_in >> shamt) & mask;
        field_new = (dec.overwrite ? dec.operand : old_val + dec.operand) & mask;
        word_out  = (word_in & ~(mask << shamt)) | (field_new << shamt);
    end
endmodule

// File: rtl/acf_bank.sv
module acf_bank
    import acf_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    assign rdata = mem[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end
endmodule

// File: rtl/atomic_counter_file.sv
module atomic_counter_file
    import acf_pkg::*;
#(
    parameter int DEPTH_BYTES = 2048,
    localparam int ADDR_W = $clog2(DEPTH_BYTES),
    localparam int WORDS  = DEPTH_BYTES / (1 << LANE_W),
    localparam int IDX_W  = ADDR_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_is_load,
    input  logic [REQ_W-1:0]  req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data
);
    req_dec_t          dec;
    logic [IDX_W-1:0]  word_idx;
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] nxt_word;
    logic [DATA_W-1:0] old_val;
    logic              do_write;

    acf_decode #(.ADDR_W(ADDR_W)) u_decode (
        .is_load  (req_is_load),
        .addr     (req_addr),
        .wdata    (req_wdata),
        .word_idx (word_idx),
        .dec      (dec)
    );

    acf_bank #(.WORDS(WORDS)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .idx   (word_idx),
        .we    (do_write),
        .wdata (nxt_word),
        .rdata (cur_word)
    );

    acf_lane_alu u_alu (
        .word_in  (cur_word),
        .dec      (dec),
        .old_val  (old_val),
        .word_out (nxt_word)
    );

    assign do_write = req_valid && !dec.misaligned;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && dec.misaligned;
            if (req_valid && req_is_load && !dec.misaligned)
                rsp_data <= sext_sz(old_val, dec.size);
            else
                rsp_data <= '0;
        end
    end
endmodule

// File: rtl/acf_checker.sv
module acf_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_is_load,
    input logic [1:0]  req_size,
    input logic [2:0]  req_low,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [63:0] rsp_data
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !rsp_err));

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_byte_sext_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_load && req_size == 2'd0) |=> (rsp_data[63:8] == {56{rsp_data[7]}}));

    assert_store_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_is_load) |=> (rsp_data == 64'd0));

    assert_misalign_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd3 && req_low != 3'd0) |=> rsp_err);

    assert_byte_never_err_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd0) |=> !rsp_err);

    assert_err_data_zero_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_data == 64'd0));
endmodule

bind atomic_counter_file acf_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_is_load (req_is_load),
    .req_size    (req_addr[12:11]),
    .req_low     (req_addr[2:0]),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_data    (rsp_data)
);

// File: tb/atomic_counter_file_tb.sv
module atomic_counter_file_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_is_load;
    logic [35:0] req_addr;
    logic [63:0] req_wdata;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [7:0] ref_mem [2048];

    always #2.5 clk = ~clk;

    atomic_counter_file u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_load(req_is_load),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    function automatic logic [63:0] sx(logic [63:0] v, int nb);
        int s = 64 - 8 * nb;
        return 64'($signed(v << s) >>> s);
    endfunction

    function automatic logic [63:0] mk(int nb);
        return (nb == 8) ? '1 : ((64'd1 << (8 * nb)) - 64'd1);
    endfunction

    function automatic logic [63:0] ref_rd(int a, int nb);
        logic [63:0] v = '0;
        for (int i = 0; i < nb; i++) v = (v << 8) | 64'(ref_mem[a + i]);
        return v;
    endfunction

    task automatic ref_wr(int a, int nb, logic [63:0] v);
        for (int i = nb - 1; i >= 0; i--) begin
            ref_mem[a + i] = v[7:0];
            v = v >> 8;
        end
    endtask

    function automatic logic [35:0] mk_addr(logic [21:0] inc, bit mode, int sz, int a);
        return {inc, mode, 2'(sz), 11'(a)};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge.
    task automatic op(string tag, bit ld, logic [21:0] inc, bit mode, int sz, int a,
                      logic [63:0] wd);
        int nb = 1 << sz;
        bit mis = (a % nb) != 0;
        logic [63:0] old, nv, opnd, exp_d;
        old   = mis ? 64'd0 : ref_rd(a, nb);
        opnd  = ld ? {{42{inc[21]}}, inc} : wd;
        nv    = ((!ld && mode) ? opnd : old + opnd) & mk(nb);
        exp_d = (ld && !mis) ? sx(old, nb) : 64'd0;
        req_valid = 1; req_is_load = ld; req_addr = mk_addr(inc, mode, sz, a); req_wdata = wd;
        @(negedge clk);
        check({tag, " valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " err"}, 64'(rsp_err), 64'(mis));
        check({tag, " data"}, rsp_data, exp_d);
        if (!mis) ref_wr(a, nb, nv);
    endtask

    task automatic idle();
        req_valid = 0; req_is_load = 0; req_addr = '0; req_wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 2048; i++) ref_mem[i] = 8'd0;
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        check("R1 rsp_valid at reset", 64'(rsp_valid), 64'd0);
        check("R1 rsp_err at reset", 64'(rsp_err), 64'd0);
        rst = 0;
        // R1: counters read zero, including the top word
        op("R1 zero low", 1, 22'd0, 0, 3, 0, 0);
        op("R1 zero top", 1, 22'd0, 0, 3, 2040, 0);
        // R5 then R7: big-endian placement
        op("R5 overwrite64", 0, 22'd0, 1, 3, 8, 64'h0102030405060708);
        op("R7 msb byte", 1, 22'd0, 0, 0, 8, 0);
        op("R7 lsb byte", 1, 22'd0, 0, 0, 15, 0);
        op("R7 mid half", 1, 22'd0, 0, 1, 10, 0);
        // R4 byte add with wrap, R6 neighbours kept
        op("R4 byte add wrap", 0, 22'd0, 0, 0, 9, 64'hFFFF_FFFF_FFFF_FFFF);
        op("R6 word after byte add", 1, 22'd0, 0, 3, 8, 0);
        // R3 negative increment on 32-bit counter
        op("R3 neg inc", 1, 22'h3FFFFF, 0, 2, 16, 0);
        op("R3 neg result", 1, 22'd0, 0, 2, 16, 0);
        op("R6 other half untouched", 1, 22'd0, 0, 2, 20, 0);
        // R3 most negative increment on 64-bit
        op("R3 min inc", 1, 22'h200000, 0, 3, 32, 0);
        op("R3 min result", 1, 22'd0, 0, 3, 32, 0);
        // R9 back-to-back on same counter
        op("R9 b2b 0", 1, 22'd5, 0, 3, 24, 0);
        op("R9 b2b 1", 1, 22'd5, 0, 3, 24, 0);
        op("R9 b2b 2", 1, 22'd5, 0, 3, 24, 0);
        // R8 misaligned rejected, storage unchanged
        op("R8 misaligned 64", 1, 22'd7, 0, 3, 28, 0);
        op("R8 misaligned 16", 0, 22'd0, 1, 1, 25, 64'hABCD);
        op("R8 unchanged", 1, 22'd0, 0, 3, 24, 0);
        // R5 16-bit overwrite, R2 sign extension of read
        op("R5 overwrite16", 0, 22'd0, 1, 1, 2044, 64'h1234_8001);
        op("R2 sext16", 1, 22'd1, 0, 1, 2044, 0);
        idle();
        @(negedge clk);
        check("R2 no request no rsp", 64'(rsp_valid), 64'd0);
        // Random mix on the low 64 bytes
        for (int k = 0; k < 600; k++) begin
            int sz = int'($urandom_range(3, 0));
            int nb = 1 << sz;
            int a  = int'($urandom_range(63, 0));
            bit ld = $urandom_range(1, 0) == 1;
            bit md = $urandom_range(1, 0) == 1;
            if ($urandom_range(7, 0) != 0) a = a - (a % nb);
            op(ld ? "R3 rand load" : (md ? "R5 rand store" : "R4 rand add"),
               ld, 22'($urandom), md, sz, a, {$urandom, $urandom});
            if ($urandom_range(3, 0) == 0) begin
                idle();
                @(negedge clk);
                check("R2 idle", 64'(rsp_valid), 64'd0);
            end
        end
        // Final sweep: R6 every byte matches the model
        for (int a = 0; a < 64; a += 8) op("R6 sweep", 1, 22'd0, 0, 3, a, 0);
        idle();
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule